// File: doc/BRIEF.md
# Interrupt Claim/Complete Controller

This block gathers level-sensitive interrupt lines from a set of sources and offers them to a small number of target contexts. Each source has a priority. Each context has its own enable bit for every source and its own threshold. A context picks up work by reading its claim/complete register. The read returns the best source that is pending and visible to that context, and moves that source into service. The context signals the end of the handler by writing a source number back to the same register.

A completion is judged only against the writing context's enable bits as they stand at the time of the write. It is never compared with the number that the context last claimed. A completion for a source that the context has disabled is discarded without any trace. The source then stays in service until some later completion is accepted. No mask register exists beyond the enable bits.

A build-time switch selects a second variant. In that variant a claim also hides the claimed source from the claiming context until that context completes it.

Top module: `irq_claim_ctrl`

## Requirements
- R1: After reset, every pending bit, in-service bit, enable bit, priority and threshold is zero, `reg_rdata` is zero and every `ctx_irq` bit is low.
- R2: A source whose input is high and which is not in service has its pending bit set at the next clock edge. The pending bit stays set until the source is claimed. The pending vector reads at address 0x00 with source s in bit s.
- R3: A read of the claim register of context c (address 0xC0+c) returns, on `reg_rdata` after that edge, the number of the pending source enabled for c that has the largest priority. A tie goes to the lower number. The read returns 0 when no source qualifies, and such a read changes no state.
- R4: A claim that returns a source clears its pending bit and puts it in service. A source in service never becomes pending while its input stays high.
- R5: An accepted completion takes the source out of service. If its input is still high, its pending bit is set again one edge later, never at the completion edge itself.
- R6: A completion is accepted whenever its number is enabled for the writing context, whichever context claimed the source and whichever source that context claimed last.
- R7: A completion that names a source not enabled for the writing context has no effect. The source stays in service and cannot be claimed until a later completion is accepted.
- R8: A completion value of 0, or of any value above the source count (no truncation of the upper bits), has no effect.
- R9: `ctx_irq[c]` is high exactly when some pending source visible to c has a priority strictly above the threshold of c. When it is high, a claim by c would return a nonzero number.
- R10: In the default variant a claim never alters any enable bit, and a source that another context completed can be claimed again at once by the context that first claimed it.
- R11: With `AUTO_MASK` set, a claim by context c hides that source from c until c itself completes it (accepted against the enable bit). Completions from other contexts do not reveal it. The enable register reads back unchanged.
- R12: Priority registers (0x00+s, s≥1, low `PRIO_W` bits), enable registers (0x40+c, source s in bit s, bit 0 reads 0) and threshold registers (0x80+c, low `PRIO_W` bits) read back what was written, one cycle after `reg_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_level | input | N_SRC | Level interrupt inputs; bit s is source s |
| reg_re | input | 1 | Register read strobe (a claim when aimed at a claim register) |
| reg_we | input | 1 | Register write strobe (a completion when aimed at a claim register) |
| reg_addr | input | ADDR_W | Register address: top 2 bits pick the bank, the rest the index |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered on the edge that takes `reg_re` |
| ctx_irq | output | N_CTX | Interrupt request, one per context |

## Verification
The subtle overlap is between a completion write and a source input that is still high in the same cycle. The completion releases the source, and the gateway must not set the pending bit again until the following edge. The bench holds every input high while it completes claimed sources in an order unrelated to the claim order. It then reads the pending vector and expects every released source to be pending again. A checker property also forbids a pending bit rising on the edge where the in-service bit falls. The second overlap is a claim by one context after another context has completed the same source. This is judged by comparing the claim results of the two build variants.

// File: rtl/icc_pkg.sv
// Shared definitions for the interrupt claim/complete controller.
// Assumes the register address is split into a 2-bit bank field on top
// and an index field below it.
package icc_pkg;

    localparam int REGION_W = 2;

    typedef enum logic [REGION_W-1:0] {
        RGN_PRIO   = 2'd0,
        RGN_ENABLE = 2'd1,
        RGN_THRESH = 2'd2,
        RGN_CLAIM  = 2'd3
    } icc_region_e;

endpackage

// File: rtl/icc_gateway.sv
// Per-source pending and in-service state.
// Assumes claim_set and done_clr never name the same source in one cycle
// (the single register port allows only one access per cycle).
module icc_gateway #(
    parameter int N_SRC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC:1]   level,
    input  logic [N_SRC:1]   claim_set,
    input  logic [N_SRC:1]   done_clr,
    output logic [N_SRC:1]   pending,
    output logic [N_SRC:1]   in_svc
);

    for (genvar s = 1; s <= N_SRC; s++) begin : g_src
        logic pend_q;
        logic svc_q;

        // Track one source: pend while idle and high, serve from claim to completion.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
                svc_q  <= 1'b0;
            end else begin
                svc_q  <= (svc_q | claim_set[s]) & ~done_clr[s];
                pend_q <= (pend_q | (level[s] & ~svc_q)) & ~claim_set[s];
            end
        end

        assign pending[s] = pend_q;
        assign in_svc[s]  = svc_q;
    end

endmodule

// File: rtl/icc_arbiter.sv
// Picks the best candidate source by priority (lowest number on a tie)
// and flags whether any candidate lies above the threshold.
// Purely combinational; assumes cand already excludes invisible sources.
module icc_arbiter #(
    parameter int N_SRC  = 7,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 3
) (
    input  logic [N_SRC:1]             cand,
    input  logic [N_SRC:1][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]          thresh,
    output logic [ID_W-1:0]            best_id,
    output logic                       fire
);

    logic [PRIO_W-1:0] best_p;
    logic              found;
    logic [N_SRC:1]    above;

    // Scan upward; only a strictly larger priority displaces the holder.
    always_comb begin
        best_id = '0;
        best_p  = '0;
        found   = 1'b0;
        for (int s = 1; s <= N_SRC; s++) begin
            if (cand[s] && (!found || prio[s] > best_p)) begin
                best_id = ID_W'(s);
                best_p  = prio[s];
                found   = 1'b1;
            end
        end
    end

    for (genvar s = 1; s <= N_SRC; s++) begin : g_above
        assign above[s] = cand[s] && (prio[s] > thresh);
    end

    assign fire = |above;

endmodule

// File: rtl/icc_context.sv
// One target context: enable bits, threshold, optional claim-hiding
// and its arbiter. done_req must only be raised with a done_id in 1..N_SRC.
module icc_context #(
    parameter int N_SRC     = 7,
    parameter int PRIO_W    = 3,
    parameter int ID_W      = 3,
    parameter bit AUTO_MASK = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_SRC:1]             pending,
    input  logic [N_SRC:1][PRIO_W-1:0] prio,
    input  logic                       en_we,
    input  logic [N_SRC:1]             en_wdata,
    input  logic                       thr_we,
    input  logic [PRIO_W-1:0]          thr_wdata,
    input  logic                       claim_take,
    input  logic                       done_req,
    input  logic [ID_W-1:0]            done_id,
    output logic [N_SRC:1]             enable,
    output logic [PRIO_W-1:0]          thresh,
    output logic [ID_W-1:0]            best_id,
    output logic                       fire,
    output logic [N_SRC:1]             take_hot,
    output logic [N_SRC:1]             done_hot
);

    logic [N_SRC:1] hidden;
    logic [N_SRC:1] cand;

    // Hold the enable bits and threshold written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '0;
            thresh <= '0;
        end else begin
            if (en_we)  enable <= en_wdata;
            if (thr_we) thresh <= thr_wdata;
        end
    end

    // Decode the claimed source and the accepted completion into one-hot vectors.
    always_comb begin
        for (int s = 1; s <= N_SRC; s++) begin
            take_hot[s] = claim_take && (best_id == ID_W'(s));
            done_hot[s] = done_req && (done_id == ID_W'(s)) && enable[s];
        end
    end

    if (AUTO_MASK) begin : g_hide
        // Hide a claimed source from this context until this context completes it.
        always_ff @(posedge clk) begin
            if (!rst_n) hidden <= '0;
            else        hidden <= (hidden | take_hot) & ~done_hot;
        end
    end else begin : g_nohide
        assign hidden = '0;
    end

    assign cand = pending & enable & ~hidden;

    icc_arbiter #(
        .N_SRC  (N_SRC),
        .PRIO_W (PRIO_W),
        .ID_W   (ID_W)
    ) u_arb (
        .cand    (cand),
        .prio    (prio),
        .thresh  (thresh),
        .best_id (best_id),
        .fire    (fire)
    );

endmodule

// File: rtl/irq_claim_ctrl.sv
// Interrupt claim/complete controller top: register decode, source
// priorities, gateway and one context slice per target.
// Assumes reg_re and reg_we are never high in the same cycle.
module irq_claim_ctrl
    import icc_pkg::*;
#(
    parameter int N_SRC     = 7,
    parameter int N_CTX     = 2,
    parameter int PRIO_W    = 3,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter bit AUTO_MASK = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC:1]    src_level,
    input  logic              reg_re,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [N_CTX-1:0]  ctx_irq
);

    localparam int ID_W  = $clog2(N_SRC + 1);
    localparam int IDX_W = ADDR_W - REGION_W;

    icc_region_e                          rgn;
    logic [IDX_W-1:0]                     idx;
    logic                                 id_ok;
    logic [N_SRC:1][PRIO_W-1:0]           prio_q;
    logic [N_SRC:1]                       src_pend;
    logic [N_SRC:1]                       src_svc;
    logic [N_SRC:1]                       claim_set;
    logic [N_SRC:1]                       done_clr;
    logic [N_CTX-1:0][N_SRC:1]            ctx_en;
    logic [N_CTX-1:0][PRIO_W-1:0]         ctx_thr;
    logic [N_CTX-1:0][ID_W-1:0]           ctx_best;
    logic [N_CTX-1:0][N_SRC:1]            ctx_take;
    logic [N_CTX-1:0][N_SRC:1]            ctx_done;
    logic [DATA_W-1:0]                    rd_next;

    assign rgn   = icc_region_e'(reg_addr[ADDR_W-1 -: REGION_W]);
    assign idx   = reg_addr[IDX_W-1:0];
    assign id_ok = (reg_wdata != '0) && (reg_wdata <= DATA_W'(N_SRC));

    // Store the per-source priorities written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
        end else begin
            for (int s = 1; s <= N_SRC; s++) begin
                if (reg_we && rgn == RGN_PRIO && idx == IDX_W'(s))
                    prio_q[s] <= reg_wdata[PRIO_W-1:0];
            end
        end
    end

    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
        logic hit;
        assign hit = (idx == IDX_W'(c));

        icc_context #(
            .N_SRC     (N_SRC),
            .PRIO_W    (PRIO_W),
            .ID_W      (ID_W),
            .AUTO_MASK (AUTO_MASK)
        ) u_ctx (
            .clk        (clk),
            .rst_n      (rst_n),
            .pending    (src_pend),
            .prio       (prio_q),
            .en_we      (reg_we && rgn == RGN_ENABLE && hit),
            .en_wdata   (reg_wdata[N_SRC:1]),
            .thr_we     (reg_we && rgn == RGN_THRESH && hit),
            .thr_wdata  (reg_wdata[PRIO_W-1:0]),
            .claim_take (reg_re && rgn == RGN_CLAIM && hit),
            .done_req   (reg_we && rgn == RGN_CLAIM && hit && id_ok),
            .done_id    (reg_wdata[ID_W-1:0]),
            .enable     (ctx_en[c]),
            .thresh     (ctx_thr[c]),
            .best_id    (ctx_best[c]),
            .fire       (ctx_irq[c]),
            .take_hot   (ctx_take[c]),
            .done_hot   (ctx_done[c])
        );
    end

    // Merge the claim and completion decisions of all contexts.
    always_comb begin
        claim_set = '0;
        done_clr  = '0;
        for (int c = 0; c < N_CTX; c++) begin
            claim_set = claim_set | ctx_take[c];
            done_clr  = done_clr  | ctx_done[c];
        end
    end

    icc_gateway #(
        .N_SRC (N_SRC)
    ) u_gw (
        .clk       (clk),
        .rst_n     (rst_n),
        .level     (src_level),
        .claim_set (claim_set),
        .done_clr  (done_clr),
        .pending   (src_pend),
        .in_svc    (src_svc)
    );

    // Select the read value for the addressed register.
    always_comb begin
        rd_next = '0;
        unique case (rgn)
            RGN_PRIO: begin
                if (idx == '0) rd_next[N_SRC:1] = src_pend;
                for (int s = 1; s <= N_SRC; s++)
                    if (idx == IDX_W'(s)) rd_next[PRIO_W-1:0] = prio_q[s];
            end
            RGN_ENABLE: begin
                for (int c = 0; c < N_CTX; c++)
                    if (idx == IDX_W'(c)) rd_next[N_SRC:1] = ctx_en[c];
            end
            RGN_THRESH: begin
                for (int c = 0; c < N_CTX; c++)
                    if (idx == IDX_W'(c)) rd_next[PRIO_W-1:0] = ctx_thr[c];
            end
            RGN_CLAIM: begin
                for (int c = 0; c < N_CTX; c++)
                    if (idx == IDX_W'(c)) rd_next[ID_W-1:0] = ctx_best[c];
            end
            default: rd_next = '0;
        endcase
    end

    // Register the read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_re) reg_rdata <= rd_next;
    end

endmodule

// File: rtl/icc_checker.sv
// Property checker for irq_claim_ctrl, attached by bind below.
// Observes the register port, gateway state and per-context results.
module icc_checker #(
    parameter int N_SRC  = 7,
    parameter int N_CTX  = 2,
    parameter int ID_W   = 3,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      reg_re,
    input logic                      reg_we,
    input logic [ADDR_W-1:0]         reg_addr,
    input logic [DATA_W-1:0]         reg_wdata,
    input logic [N_SRC:1]            pending,
    input logic [N_SRC:1]            in_svc,
    input logic [N_CTX-1:0][N_SRC:1] ctx_en,
    input logic [N_CTX-1:0][ID_W-1:0] ctx_best,
    input logic [N_CTX-1:0]          ctx_irq
);

    localparam int IDX_W = ADDR_W - 2;

    logic claim_bank;
    assign claim_bank = (reg_addr[ADDR_W-1 -: 2] == 2'd3);

    // R4: a source is never pending and in service together.
    p_svc_excl_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(pending & in_svc)));

    // R5: the pending bit may not rise on the edge that ends service.
    p_repend_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(|($past(in_svc) & ~in_svc & pending)));

    // R6: at most one source enters or leaves service per edge.
    p_single_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_svc ^ $past(in_svc)) <= 1);

    for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
        logic hit;
        logic claim_rd;
        logic done_wr;
        logic en_hit;

        assign hit      = (reg_addr[IDX_W-1:0] == IDX_W'(c));
        assign claim_rd = reg_re && claim_bank && hit;
        assign done_wr  = reg_we && claim_bank && hit;

        // Find whether the written number is enabled for this context.
        always_comb begin
            en_hit = 1'b0;
            for (int s = 1; s <= N_SRC; s++)
                if (reg_wdata == DATA_W'(s) && ctx_en[c][s]) en_hit = 1'b1;
        end

        // R9: a raised request always has a claimable winner.
        p_irq_has_winner_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ctx_irq[c] |-> ctx_best[c] != '0);

        // R3: an empty claim leaves the service state alone.
        p_empty_claim_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (claim_rd && ctx_best[c] == '0) |=> $stable(in_svc));

        // R4: a successful claim adds exactly one source to service.
        p_claim_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (claim_rd && ctx_best[c] != '0) |=>
                $countones(in_svc) == $countones($past(in_svc)) + 1);

        // R10: a claim never rewrites enable bits.
        p_claim_keeps_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
            claim_rd |=> $stable(ctx_en[c]));

        // R7: a completion for a number not enabled changes nothing.
        p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (done_wr && !en_hit) |=> $stable(in_svc));
    end

endmodule

bind irq_claim_ctrl icc_checker #(
    .N_SRC  (N_SRC),
    .N_CTX  (N_CTX),
    .ID_W   (ID_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_re    (reg_re),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pending   (src_pend),
    .in_svc    (src_svc),
    .ctx_en    (ctx_en),
    .ctx_best  (ctx_best),
    .ctx_irq   (ctx_irq)
);

// File: tb/tb_irq_claim_ctrl.sv
// Bench: sweeps priority/enable/threshold patterns on the default variant,
// then directed drop, stray-value and hiding cases on both variants.
module tb_irq_claim_ctrl;

    localparam int N_SRC = 7;
    localparam int N_CTX = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_SRC:1]    src_level = '0;
    logic              reg_re = 1'b0;
    logic              reg_we = 1'b0;
    logic              sel = 1'b0;
    logic [7:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       rd_c;
    logic [31:0]       rd_a;
    logic [N_CTX-1:0]  irq_c;
    logic [N_CTX-1:0]  irq_a;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    int prio_m [1:N_SRC];

    always #10 clk = ~clk;

    irq_claim_ctrl #(.AUTO_MASK(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .src_level(src_level),
        .reg_re(reg_re & ~sel), .reg_we(reg_we & ~sel),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rd_c), .ctx_irq(irq_c));

    irq_claim_ctrl #(.AUTO_MASK(1'b1)) dut_am (
        .clk(clk), .rst_n(rst_n), .src_level(src_level),
        .reg_re(reg_re & sel), .reg_we(reg_we & sel),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(rd_a), .ctx_irq(irq_a));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        @(negedge clk);
        reg_re = 1'b0;
        d = sel ? rd_a : rd_c;
    endtask

    function automatic int best_of(input int mask);
        int b  = 0;
        int bp = -1;
        for (int s = 1; s <= N_SRC; s++)
            if (mask[s] && prio_m[s] > bp) begin b = s; bp = prio_m[s]; end
        return b;
    endfunction

    function automatic logic [7:0] a_en(input int c);  return 8'(8'h40 + c); endfunction
    function automatic logic [7:0] a_thr(input int c); return 8'(8'h80 + c); endfunction
    function automatic logic [7:0] a_clm(input int c); return 8'(8'hC0 + c); endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", 32'(irq_c), 32'h0);
        chk("R1 rdata", rd_c, 32'h0);
        rd(8'h00, d); chk("R1 pending", d, 32'h0);
        rd(a_clm(0), d); chk("R1 claim", d, 32'h0);
        rd(a_en(1), d); chk("R1 enable", d, 32'h0);

        // R12: register read-back and field widths
        wr(8'h03, 32'h5); rd(8'h03, d); chk("R12 prio", d, 32'h5);
        wr(8'h03, 32'hFA); rd(8'h03, d); chk("R12 prio width", d, 32'h2);
        wr(a_en(1), 32'hFFFF_FFFF); rd(a_en(1), d); chk("R12 enable", d, 32'hFE);
        wr(a_thr(1), 32'h6); rd(a_thr(1), d); chk("R12 thresh", d, 32'h6);
        wr(a_en(1), 32'h0);

        // R2: pending latch
        src_level[3] = 1'b1;
        rd(8'h00, d); chk("R2 pending set", d, 32'h08);
        src_level[3] = 1'b0;
        rd(8'h00, d); chk("R2 pending held", d, 32'h08);

        // Sweep: all inputs high, varied priorities, enables and thresholds
        src_level = '1;
        @(negedge clk);
        for (int t = 0; t < 24; t++) begin
            int em;
            int thr;
            int pm;
            bit exp_irq;
            for (int s = 1; s <= N_SRC; s++) begin
                prio_m[s] = (t * 3 + s * 5 + s * t) % 8;
                wr(8'(s), 32'(prio_m[s]));
            end
            em  = (((t * 45 + 17) % 127) + 1) << 1;
            thr = t % 8;
            wr(a_en(0), 32'(em));
            wr(a_thr(0), 32'(thr));
            exp_irq = 1'b0;
            for (int s = 1; s <= N_SRC; s++)
                if (em[s] && prio_m[s] > thr) exp_irq = 1'b1;
            chk("R9 sweep irq", 32'(irq_c[0]), 32'(exp_irq));
            pm = 32'hFE;
            for (int k = 0; k <= N_SRC; k++) begin
                int e;
                e = best_of(pm & em);
                rd(a_clm(0), d);
                chk("R3 sweep claim", d, 32'(e));
                if (e == 0) break;
                pm = pm & ~(1 << e);
            end
            rd(8'h00, d); chk("R4 served not pending", d, 32'(pm));
            rd(a_en(0), d); chk("R10 enable kept", d, 32'(em));
            // R6: complete in ascending order, unrelated to claim order
            for (int s = 1; s <= N_SRC; s++)
                if (em[s]) wr(a_clm(0), 32'(s));
            rd(8'h00, d); chk("R5 re-pending", d, 32'hFE);
        end

        // R7: completion while disabled is dropped
        wr(a_en(0), 32'h04); wr(a_en(1), 32'h0);
        rd(a_clm(0), d); chk("R3 single", d, 32'h2);
        wr(a_en(0), 32'h0);
        wr(a_clm(0), 32'h2);
        wr(a_clm(1), 32'h2);
        wr(a_en(0), 32'h04);
        rd(8'h00, d); chk("R7 stuck", d, 32'hFA);
        rd(a_clm(0), d); chk("R7 no reclaim", d, 32'h0);

        // R8: stray completion values
        wr(a_clm(0), 32'h0);
        wr(a_clm(0), 32'h8);
        wr(a_clm(0), 32'h102);
        rd(8'h00, d); chk("R8 no effect", d, 32'hFA);

        wr(a_clm(0), 32'h2);
        rd(8'h00, d); chk("R7 recovered", d, 32'hFE);

        // R6: another context completes a source claimed by context 0
        rd(a_clm(0), d); chk("R6 claim", d, 32'h2);
        wr(a_en(1), 32'h04);
        wr(a_clm(1), 32'h2);
        rd(8'h00, d); chk("R6 foreign completion", d, 32'hFE);

        // R9: threshold boundary
        wr(8'h02, 32'h4);
        wr(a_thr(0), 32'h4);
        chk("R9 equal threshold", 32'(irq_c[0]), 32'h0);
        wr(a_thr(0), 32'h3);
        chk("R9 above threshold", 32'(irq_c[0]), 32'h1);

        // R10: default variant, source completed by context 1 is reclaimable
        wr(8'h04, 32'h6); wr(8'h05, 32'h2);
        wr(a_en(0), 32'h30); wr(a_en(1), 32'h10);
        rd(a_clm(0), d); chk("R10 claim", d, 32'h4);
        wr(a_clm(1), 32'h4);
        rd(a_clm(0), d); chk("R10 reclaim", d, 32'h4);

        // R11: hiding variant
        sel = 1'b1;
        wr(8'h04, 32'h6); wr(8'h05, 32'h2);
        wr(a_en(0), 32'h30); wr(a_en(1), 32'h10);
        rd(a_clm(0), d); chk("R11 claim", d, 32'h4);
        rd(a_en(0), d); chk("R11 enable kept", d, 32'h30);
        wr(a_clm(1), 32'h4);
        rd(a_clm(0), d); chk("R11 hidden", d, 32'h5);
        rd(a_clm(1), d); chk("R11 other ctx", d, 32'h4);
        wr(a_clm(0), 32'h4);
        wr(a_clm(0), 32'h5);
        rd(a_clm(0), d); chk("R11 revealed", d, 32'h4);
        sel = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule